// File: doc/BRIEF.md
# Reed-Solomon Sector Error Applier

This block takes the result of a Reed-Solomon decode over a 512-byte sector and applies it to the sector buffer. The decoder is outside the block. Its status word and up to four error reports arrive as inputs, together with the nine parity bytes that were stored with the sector. The sector itself lives in an external single-port byte RAM. The block reaches it through a read/write port that has one cycle of read latency.

The decoder counts in 9-bit symbols, but the buffer is addressed in bytes. For each report, the block finds the byte where the symbol starts and the bit offset of the symbol inside that byte. It reads that byte and the next one and XORs the 9-bit mask into the pair. It then writes both bytes back. A symbol that straddles a byte boundary therefore changes two bytes.

Before any correction, the block checks whether the page is blank. If the stored parity is all ones, it scans the whole sector. When the data is all ones as well, the sector is reported as erased and left untouched.

Top module: `rs_sector_fixer`

## Requirements
- R1: After reset, `busy`, `done`, `ram_rd_en` and `ram_wr_en` are all low.
- R2: A report word carries a mask in bits 8:0 and a 1-based symbol number in bits 24:16. For the 0-based symbol k = number−1:
  - the first byte is k + floor(k/8);
  - the bit offset is k mod 8;
  - the mask shifted left by the offset is XORed into the 16-bit value {byte first+1, byte first}, with the low byte at the lower address.
- R3: A report whose symbol number is 0 is skipped, and the RAM is not accessed for it. The same holds for a report whose 0-based symbol is 512 or more.
- R4: Each applied report makes its RAM accesses in consecutive cycles: read first byte, read second byte, write first byte, write second byte. A read and a write never happen in the same cycle.
- R5: If the second byte address is 512 or more, that byte is neither read nor written. It is treated as zero, and only the first byte changes. If the first byte address is 512 or more, the whole report is skipped.
- R6: If status bit 1 (uncorrectable) is set, no byte is written, `fail` is 1 and `fix_count` is 0.
- R7: If status bit 0 (error present) is clear and bit 1 is clear, no byte is written, and `fail` and `fix_count` are 0.
- R8: When bit 0 is set and bit 1 is clear, `fix_count` equals status bits 31:29. Reports 0 to min(count,4)−1 are applied in that order, and report i sits in `reports_in[32*i+31 : 32*i]`.
- R9: If all nine parity bytes are 0xFF and all 512 sector bytes read as 0xFF, `erased` is 1, nothing is written, and `fail` and `fix_count` are 0, whatever the status says. If the parity is all 0xFF but some data byte is not, the decode is handled as usual.
- R10: `done` is a single-cycle pulse at the end of an operation, and the results are valid in that cycle. `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation on the presented inputs (accepted when idle) |
| status_in | input | 32 | Decoder status: bit0 error present, bit1 uncorrectable, bits 31:29 error count |
| reports_in | input | 128 | Four error-report words, report i in bits 32i+31:32i |
| parity_in | input | 72 | Nine stored parity bytes |
| ram_addr | output | 9 | Sector RAM byte address |
| ram_rd_en | output | 1 | RAM read strobe, data returns the next cycle |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Decode was uncorrectable |
| erased | output | 1 | Sector recognised as blank |
| fix_count | output | 3 | Number of corrections reported |

## Verification
The main function is driven through three kinds of test.

- **Single reports at chosen symbols.** These place reports at offset 0, at offset 7 where the mask crosses into the second byte, at the last byte of the buffer, and just past it. Together they separate a wrong byte-address formula, a wrong shift, and a missing or overrunning second-byte write.
- **Status-only patterns.** These cover uncorrectable, no error, a zero count, and a count above four. They show whether the status bits are decoded in the right order of precedence and whether the report loop is clamped.
- **Random mixes of status, reports and buffer contents.** Overlapping reports are included, and the buffer is compared against a byte-wise reference after each run. Blank pages, and pages whose parity is blank but whose data is not, check that the erased bypass fires only when both conditions hold.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;
  localparam int WORD_W        = 32;
  localparam int SYM_W         = 9;
  localparam int STAT_ERR_BIT  = 0;
  localparam int STAT_UNC_BIT  = 1;
  localparam int STAT_CNT_LSB  = 29;
  localparam int STAT_CNT_W    = 3;
  localparam int REP_IDX_LSB   = 16;
  localparam int REP_MASK_LSB  = 0;
  localparam int CALC_W        = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_SCAN_END, S_DECIDE, S_LOC,
    S_RD_LO, S_RD_HI, S_WR_LO, S_WR_HI, S_DONE
  } fix_state_t;

  // byte where a 0-based 9-bit symbol starts: k*9/8 == k + k/8
  function automatic logic [CALC_W-1:0] sym_first_byte(input logic [CALC_W-1:0] k);
    return k + (k >> 3);
  endfunction

  function automatic logic [2:0] sym_bit_off(input logic [CALC_W-1:0] k);
    return k[2:0];
  endfunction

  // XOR a shifted symbol mask into a little-endian byte pair
  function automatic logic [15:0] xor_into_pair(input logic [15:0] pair,
                                                input logic [SYM_W-1:0] mask,
                                                input logic [2:0] off);
    logic [15:0] m;
    m = 16'(mask) << off;
    return pair ^ m;
  endfunction
endpackage

// File: rtl/rs_fix_locate.sv
module rs_fix_locate
  import rs_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int AW = $clog2(SECTOR_BYTES)
) (
  input  logic [SYM_W-1:0] sym_num,
  output logic [AW-1:0]    lo_addr,
  output logic [AW-1:0]    hi_addr,
  output logic             use_ok,
  output logic             hi_ok,
  output logic [2:0]       bit_off
);
  logic [CALC_W-1:0] k;
  logic [CALC_W-1:0] first;
  logic [CALC_W-1:0] second;

  always_comb begin
    k       = CALC_W'(sym_num) - CALC_W'(1);
    first   = sym_first_byte(k);
    second  = first + CALC_W'(1);
    use_ok  = (sym_num != '0) && (k < CALC_W'(SECTOR_BYTES)) &&
              (first < CALC_W'(SECTOR_BYTES));
    hi_ok   = use_ok && (second < CALC_W'(SECTOR_BYTES));
    lo_addr = first[AW-1:0];
    hi_addr = second[AW-1:0];
    bit_off = sym_bit_off(k);
  end
endmodule

// File: rtl/rs_fix_merge.sv
module rs_fix_merge
  import rs_fix_pkg::*;
(
  input  logic [7:0]       lo_byte,
  input  logic [7:0]       hi_byte,
  input  logic [SYM_W-1:0] mask,
  input  logic [2:0]       bit_off,
  output logic [7:0]       new_lo,
  output logic [7:0]       new_hi
);
  logic [15:0] pair_out;

  always_comb begin
    pair_out = xor_into_pair({hi_byte, lo_byte}, mask, bit_off);
    new_lo   = pair_out[7:0];
    new_hi   = pair_out[15:8];
  end
endmodule

// File: rtl/rs_fix_erase.sv
module rs_fix_erase #(
  parameter int N_PARITY = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_PARITY*8-1:0] parity_flat,
  input  logic                  clear,
  input  logic                  sample,
  input  logic [7:0]            sample_byte,
  output logic                  parity_all_ff,
  output logic                  data_all_ff
);
  logic [N_PARITY-1:0] pb_ff;

  for (genvar g = 0; g < N_PARITY; g++) begin : g_par
    assign pb_ff[g] = &parity_flat[g*8 +: 8];
  end
  assign parity_all_ff = &pb_ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_all_ff <= 1'b1;
    else if (clear)  data_all_ff <= 1'b1;
    else if (sample) data_all_ff <= data_all_ff & (sample_byte == 8'hFF);
  end

  // R9: the blank flag only drops after a non-blank byte was sampled
  assert_blank_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_all_ff) |-> $past(sample && (sample_byte != 8'hFF)));
endmodule

// File: rtl/rs_sector_fixer.sv
module rs_sector_fixer
  import rs_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int N_REPORTS    = 4,
  parameter int N_PARITY     = 9,
  localparam int AW   = $clog2(SECTOR_BYTES),
  localparam int RSW  = (N_REPORTS > 1) ? $clog2(N_REPORTS) : 1,
  localparam int SELW = $clog2(N_REPORTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [WORD_W-1:0]           status_in,
  input  logic [N_REPORTS*WORD_W-1:0] reports_in,
  input  logic [N_PARITY*8-1:0]       parity_in,
  output logic [AW-1:0]               ram_addr,
  output logic                        ram_rd_en,
  output logic                        ram_wr_en,
  output logic [7:0]                  ram_wdata,
  input  logic [7:0]                  ram_rdata,
  output logic                        busy,
  output logic                        done,
  output logic                        fail,
  output logic                        erased,
  output logic [STAT_CNT_W-1:0]       fix_count
);
  fix_state_t state;

  logic [AW-1:0]         scan_addr;
  logic                  scan_vld_q;
  logic [SELW-1:0]       rep_sel;
  logic [SELW-1:0]       n_q;
  logic                  err_q, uncor_q, par_ff_q;
  logic [STAT_CNT_W-1:0] cnt_q;
  logic                  fail_q, erased_q;
  logic [STAT_CNT_W-1:0] fix_cnt_q;
  logic [7:0]            lo_q, hi_new_q;

  logic [SYM_W-1:0] num_q  [N_REPORTS];
  logic [SYM_W-1:0] mask_q [N_REPORTS];

  logic accept;
  assign accept = (state == S_IDLE) && start;

  for (genvar g = 0; g < N_REPORTS; g++) begin : g_rep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        num_q[g]  <= '0;
        mask_q[g] <= '0;
      end else if (accept) begin
        num_q[g]  <= reports_in[g*WORD_W + REP_IDX_LSB  +: SYM_W];
        mask_q[g] <= reports_in[g*WORD_W + REP_MASK_LSB +: SYM_W];
      end
    end
  end

  // current report
  logic [SYM_W-1:0] cur_num, cur_mask;
  assign cur_num  = num_q[rep_sel[RSW-1:0]];
  assign cur_mask = mask_q[rep_sel[RSW-1:0]];

  logic [AW-1:0] lo_addr, hi_addr;
  logic          use_ok, hi_ok;
  logic [2:0]    bit_off;

  rs_fix_locate #(.SECTOR_BYTES(SECTOR_BYTES)) u_locate (
    .sym_num (cur_num),
    .lo_addr (lo_addr),
    .hi_addr (hi_addr),
    .use_ok  (use_ok),
    .hi_ok   (hi_ok),
    .bit_off (bit_off)
  );

  logic [7:0] hi_in, new_lo, new_hi;
  assign hi_in = hi_ok ? ram_rdata : 8'h00;

  rs_fix_merge u_merge (
    .lo_byte (lo_q),
    .hi_byte (hi_in),
    .mask    (cur_mask),
    .bit_off (bit_off),
    .new_lo  (new_lo),
    .new_hi  (new_hi)
  );

  logic par_all_ff, data_all_ff;

  rs_fix_erase #(.N_PARITY(N_PARITY)) u_erase (
    .clk           (clk),
    .rst_n         (rst_n),
    .parity_flat   (parity_in),
    .clear         (accept),
    .sample        (scan_vld_q),
    .sample_byte   (ram_rdata),
    .parity_all_ff (par_all_ff),
    .data_all_ff   (data_all_ff)
  );

  logic last_rep;
  assign last_rep = (SELW'(rep_sel + 1'b1) == n_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      scan_addr  <= '0;
      scan_vld_q <= 1'b0;
      rep_sel    <= '0;
      n_q        <= '0;
      err_q      <= 1'b0;
      uncor_q    <= 1'b0;
      cnt_q      <= '0;
      par_ff_q   <= 1'b0;
      fail_q     <= 1'b0;
      erased_q   <= 1'b0;
      fix_cnt_q  <= '0;
      lo_q       <= '0;
      hi_new_q   <= '0;
    end else begin
      scan_vld_q <= (state == S_SCAN);
      case (state)
        S_IDLE: if (start) begin
          err_q     <= status_in[STAT_ERR_BIT];
          uncor_q   <= status_in[STAT_UNC_BIT];
          cnt_q     <= status_in[STAT_CNT_LSB +: STAT_CNT_W];
          par_ff_q  <= par_all_ff;
          erased_q  <= 1'b0;
          scan_addr <= '0;
          state     <= par_all_ff ? S_SCAN : S_DECIDE;
        end
        S_SCAN: begin
          scan_addr <= scan_addr + 1'b1;
          if (scan_addr == AW'(SECTOR_BYTES - 1)) state <= S_SCAN_END;
        end
        S_SCAN_END: state <= S_DECIDE;
        S_DECIDE: begin
          rep_sel <= '0;
          if (par_ff_q && data_all_ff) begin
            erased_q  <= 1'b1;
            fail_q    <= 1'b0;
            fix_cnt_q <= '0;
            state     <= S_DONE;
          end else if (uncor_q) begin
            fail_q    <= 1'b1;
            fix_cnt_q <= '0;
            state     <= S_DONE;
          end else if (!err_q) begin
            fail_q    <= 1'b0;
            fix_cnt_q <= '0;
            state     <= S_DONE;
          end else begin
            fail_q    <= 1'b0;
            fix_cnt_q <= cnt_q;
            n_q       <= (int'(cnt_q) > N_REPORTS) ? SELW'(N_REPORTS) : SELW'(cnt_q);
            state     <= (cnt_q == '0) ? S_DONE : S_LOC;
          end
        end
        S_LOC: begin
          if (use_ok) state <= S_RD_LO;
          else if (last_rep) state <= S_DONE;
          else begin
            rep_sel <= SELW'(rep_sel + 1'b1);
            state   <= S_LOC;
          end
        end
        S_RD_LO: state <= S_RD_HI;
        S_RD_HI: begin
          lo_q  <= ram_rdata;
          state <= S_WR_LO;
        end
        S_WR_LO: begin
          hi_new_q <= new_hi;
          state    <= S_WR_HI;
        end
        S_WR_HI: begin
          if (last_rep) state <= S_DONE;
          else begin
            rep_sel <= SELW'(rep_sel + 1'b1);
            state   <= S_LOC;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // RAM port
  logic ev_rd_lo, ev_wr_lo, ev_wr_hi;
  assign ev_rd_lo = (state == S_RD_LO);
  assign ev_wr_lo = (state == S_WR_LO);
  assign ev_wr_hi = (state == S_WR_HI) && hi_ok;

  always_comb begin
    ram_addr  = '0;
    ram_rd_en = 1'b0;
    ram_wr_en = 1'b0;
    ram_wdata = 8'h00;
    case (state)
      S_SCAN:  begin ram_addr = scan_addr; ram_rd_en = 1'b1; end
      S_RD_LO: begin ram_addr = lo_addr;   ram_rd_en = 1'b1; end
      S_RD_HI: begin ram_addr = hi_addr;   ram_rd_en = hi_ok; end
      S_WR_LO: begin ram_addr = lo_addr;   ram_wr_en = 1'b1; ram_wdata = new_lo; end
      S_WR_HI: begin ram_addr = hi_addr;   ram_wr_en = hi_ok; ram_wdata = hi_new_q; end
      default: ;
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign fail      = fail_q;
  assign erased    = erased_q;
  assign fix_count = fix_cnt_q;

  // R4: a read and a write never share a cycle
  assert_rw_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd_en && ram_wr_en));
  // R4: the first-byte write comes two cycles after its first-byte read
  assert_wr_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_lo |-> $past(ev_rd_lo, 2));
  // R4: the second-byte write directly follows the first-byte write
  assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_hi |-> $past(ev_wr_lo));
  // R6: no write for an uncorrectable decode
  assert_no_wr_uncor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> !uncor_q);
  // R9: no write once a sector is found blank
  assert_no_wr_erased_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> !erased_q);
  // R10: done is one cycle wide and only while busy
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: tb/rs_sector_fixer_tb_top.sv
module rs_sector_fixer_tb_top;
  localparam int SB = 512;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  status_in = '0;
  logic [127:0] reports_in = '0;
  logic [71:0]  parity_in = '0;
  logic [8:0]   ram_addr;
  logic         ram_rd_en, ram_wr_en;
  logic [7:0]   ram_wdata;
  logic [7:0]   ram_rdata = 8'h00;
  logic         busy, done, fail, erased;
  logic [2:0]   fix_count;

  always #2.5 clk = ~clk;

  rs_sector_fixer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .status_in(status_in),
    .reports_in(reports_in), .parity_in(parity_in), .ram_addr(ram_addr),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .busy(busy), .done(done), .fail(fail),
    .erased(erased), .fix_count(fix_count)
  );

  logic [7:0] mem     [SB];
  logic [7:0] ref_mem [SB];

  always @(posedge clk) begin
    if (ram_wr_en) mem[ram_addr] <= ram_wdata;
    if (ram_rd_en) ram_rdata <= mem[ram_addr];
  end

  int n_trc = 0;
  int done_cnt = 0;
  bit trc_wr [8];
  int trc_addr [8];
  always @(posedge clk) begin
    if (rst_n && (ram_rd_en || ram_wr_en)) begin
      if (n_trc < 8) begin
        trc_wr[n_trc]   = ram_wr_en;
        trc_addr[n_trc] = int'(ram_addr);
      end
      n_trc++;
    end
    if (done) done_cnt++;
  end

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  bit exp_fail, exp_erased;
  int exp_cnt;

  // reference model, written from the requirement text
  task automatic ref_apply(input logic [31:0] st, input logic [127:0] reps,
                           input logic [71:0] par);
    bit blank = 1;
    for (int i = 0; i < 9; i++) if (par[i*8 +: 8] != 8'hFF) blank = 0;
    if (blank) for (int i = 0; i < SB; i++) if (ref_mem[i] != 8'hFF) blank = 0;
    exp_fail = 0; exp_erased = 0; exp_cnt = 0;
    if (blank) begin exp_erased = 1; return; end
    if (st[1]) begin exp_fail = 1; return; end
    if (!st[0]) return;
    exp_cnt = int'(st[31:29]);
    for (int i = 0; i < ((exp_cnt > 4) ? 4 : exp_cnt); i++) begin
      int num, msk, k, b, off, pair;
      num = int'(reps[i*32+16 +: 9]);
      msk = int'(reps[i*32 +: 9]);
      if (num == 0) continue;
      k = num - 1;
      if (k >= SB) continue;
      b = (k * 9) / 8;
      if (b >= SB) continue;
      off = k % 8;
      pair = int'(ref_mem[b]);
      if (b + 1 < SB) pair += 256 * int'(ref_mem[b+1]);
      pair = pair ^ (msk * (1 << off));
      ref_mem[b] = 8'(pair % 256);
      if (b + 1 < SB) ref_mem[b+1] = 8'(pair / 256);
    end
  endtask

  task automatic run_op(input logic [31:0] st, input logic [127:0] reps,
                        input logic [71:0] par, input string req);
    int mism = 0;
    int first_bad = -1;
    for (int i = 0; i < SB; i++) ref_mem[i] = mem[i];
    ref_apply(st, reps, par);
    @(negedge clk);
    status_in = st; reports_in = reps; parity_in = par;
    n_trc = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 2000 && !done; w++) @(negedge clk);
    chk(done == 1'b1, req, "done seen", done, 1);
    chk(fail == exp_fail, req, "fail", fail, exp_fail);
    chk(erased == exp_erased, req, "erased", erased, exp_erased);
    chk(int'(fix_count) == exp_cnt, req, "fix_count", fix_count, exp_cnt);
    @(negedge clk);
    for (int i = 0; i < SB; i++)
      if (mem[i] !== ref_mem[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    chk(mism == 0, req, "buffer bytes mismatching (first idx in exp)", mism, first_bad);
  endtask

  function automatic logic [31:0] rep(input int num, input int msk);
    return {7'd0, 9'(num), 7'd0, 9'(msk)};
  endfunction

  function automatic logic [31:0] stat(input int cnt, input bit unc, input bit err);
    return {3'(cnt), 27'd0, unc, err};
  endfunction

  task automatic fill(input int mode);
    for (int i = 0; i < SB; i++)
      mem[i] = (mode == 0) ? 8'($urandom) : (mode == 1) ? 8'hFF : 8'h00;
  endtask

  localparam logic [71:0] PAR_FF = {9{8'hFF}};
  localparam logic [71:0] PAR_X  = 72'h11_22_33_44_55_66_77_88_99;

  initial begin
    void'($urandom(32'h5EC7));
    fill(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    chk(!ram_rd_en && !ram_wr_en, "R1", "ram strobes in reset", {ram_rd_en, ram_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);

    // R2/R4: symbol 0, full mask, access order
    fill(2);
    run_op(stat(1, 0, 1), {96'd0, rep(1, 9'h1FF)}, PAR_X, "R2");
    chk(mem[0] == 8'hFF && mem[1] == 8'h01, "R2", "sym0 bytes", {mem[1], mem[0]}, 16'h01FF);
    chk(n_trc == 4 && !trc_wr[0] && !trc_wr[1] && trc_wr[2] && trc_wr[3], "R4",
        "access kinds rd,rd,wr,wr", n_trc, 4);
    chk(trc_addr[0] == 0 && trc_addr[1] == 1 && trc_addr[2] == 0 && trc_addr[3] == 1,
        "R4", "access addresses", trc_addr[1], 1);

    // R2: offset 7 straddle (symbol k=7 -> byte 7, off 7)
    fill(2);
    run_op(stat(1, 0, 1), {96'd0, rep(8, 9'h103)}, PAR_X, "R2");
    chk(mem[7] == 8'h80 && mem[8] == 8'h81, "R2", "offset7 bytes", {mem[8], mem[7]}, 16'h8180);

    // R3: symbol number 0 skipped, no RAM access
    fill(0);
    run_op(stat(1, 0, 1), {96'd0, rep(0, 9'h1FF)}, PAR_X, "R3");
    chk(n_trc == 0, "R3", "ram accesses for skipped report", n_trc, 0);

    // R5: k=455 -> byte 511, second byte suppressed; k=456 -> byte 513 skipped
    fill(0);
    run_op(stat(2, 0, 1), {64'd0, rep(457, 9'h1FF), rep(456, 9'h1FF)}, PAR_X, "R5");
    chk(n_trc == 2 && !trc_wr[0] && trc_wr[1] && trc_addr[1] == 511, "R5",
        "edge accesses", n_trc, 2);

    // R6: uncorrectable
    fill(0);
    run_op(stat(3, 1, 1), {96'd0, rep(5, 9'h0AA)}, PAR_X, "R6");
    chk(n_trc == 0, "R6", "ram accesses on uncorrectable", n_trc, 0);

    // R7: no error flag
    run_op(stat(3, 0, 0), {96'd0, rep(5, 9'h0AA)}, PAR_X, "R7");
    // R8: count 0 and count clamped from 6 to 4
    run_op(stat(0, 0, 1), {96'd0, rep(5, 9'h0AA)}, PAR_X, "R8");
    run_op(stat(6, 0, 1), {rep(40, 9'h11), rep(30, 9'h22), rep(20, 9'h44), rep(10, 9'h88)},
           PAR_X, "R8");

    // R9: blank sector bypass, and blank parity with dirty data
    fill(1);
    run_op(stat(1, 0, 1), {96'd0, rep(3, 9'h1FF)}, PAR_FF, "R9");
    mem[300] = 8'h7F;
    run_op(stat(1, 0, 1), {96'd0, rep(3, 9'h1FF)}, PAR_FF, "R9");

    // R10: start while busy is ignored
    fill(1);
    done_cnt = 0;
    @(negedge clk);
    status_in = stat(1, 1, 1); parity_in = PAR_FF;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    status_in = stat(2, 0, 1); parity_in = PAR_X;
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int w = 0; w < 2000 && !done; w++) @(negedge clk);
    chk(erased == 1'b1 && fail == 1'b0, "R10", "result of first op", {erased, fail}, 2);
    repeat (20) @(negedge clk);
    chk(done_cnt == 1 && !busy, "R10", "done pulses", done_cnt, 1);

    // random mix (R2, R8, R9)
    for (int t = 0; t < 40; t++) begin
      int mode = int'($urandom_range(0, 9));
      logic [127:0] reps;
      logic [71:0]  par;
      logic [31:0]  st;
      fill(mode < 2 ? 1 : 0);
      par = (mode < 3) ? PAR_FF : {$urandom, $urandom, 8'($urandom)};
      for (int i = 0; i < 4; i++)
        reps[i*32 +: 32] = ($urandom_range(0, 3) == 0) ? rep(int'($urandom_range(440, 511)), int'($urandom))
                                                       : rep(int'($urandom_range(0, 60)), int'($urandom));
      st = stat(int'($urandom_range(0, 7)), ($urandom_range(0, 7) == 0), ($urandom_range(0, 4) != 0));
      run_op(st, reps, par, "R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule